// File: doc/BRIEF.md
# RC oscillator calibration sequencer

This block calibrates two on-chip RC oscillators from the readings of a period counter that runs elsewhere. The period counter reports how many reference clocks fit into a fixed number of oscillator cycles and flags each fresh reading with a one-cycle strobe. Software or a power-up controller issues a start command with a mode bit. The sequencer then drives the oscillator tune codes, waits for the counter to settle after every change, reads the result and, for the slow oscillator, produces the fixed-point divisor that a downstream tick divider uses.

A slow-mode run has three phases. First it restores the slow tune code and the divisor to their reset values and reads a baseline period. It then writes a rounded and clamped coarse tune step. Finally it collects eight period samples, forms their rounded mean and divides a fixed numerator by that mean with a bit-serial restoring divider. A fast-mode run sweeps the fast tune code upward from its most negative value. It stops at the first code whose period reaches the target, or at the top code. Either run ends with a one-cycle done pulse.

Top module: `rc_cal_seq`

## Requirements
- R1: Out of reset, slow_tune_o is 0, fast_tune_o is 0, divisor_o is 16'h5000 (5 integer bits 15:11, 11 fraction bits 10:0, so divide by 10.0) and done_o is 0.
- R2: A slow-mode start (mode_i = 0) accepted in idle sets slow_tune_o to 0 and divisor_o to 16'h5000 on the next clock.
- R3: The coarse slow step is (19600 - P) / 800 with division truncating toward zero, where P is the baseline period taken with tune 0. The step is clamped to -8..+7 and written as 4-bit two's complement to slow_tune_o.
- R4: No period reading is used until a settle wait has elapsed after the preceding tune write. The wait is SLOW_SETTLE_US or FAST_SETTLE_US times CLK_MHZ reference cycles, and ten slow waits precede the end of a slow run. A reading is taken on the first period_vld_i strobe once the wait is over.
- R5: After the coarse step and its settle wait, eight readings are averaged as (sum + 4) / 8. divisor_o becomes the low 16 bits of 384000000 / average, and it changes only at the start of a slow run or at its end.
- R6: A fast-mode start (mode_i = 1) sets fast_tune_o to -16 (5'b10000). After each settle wait the code is raised by one, and the sweep stops at the first code whose period reading is at least 256.
- R7: If no code reaches 256, the fast sweep ends with fast_tune_o at +15 (5'b01111).
- R8: A start request arriving while a run is in progress is ignored. The running calibration finishes with its own results, and the other mode's outputs stay unchanged.
- R9: done_o is high for exactly one cycle at the end of each run.
- R10: A slow run leaves fast_tune_o unchanged; a fast run leaves slow_tune_o and divisor_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled in idle only |
| mode_i | input | 1 | 0 selects slow calibration, 1 selects fast calibration |
| period_i | input | 16 | Latest period counter reading |
| period_vld_i | input | 1 | One-cycle strobe marking a fresh period reading |
| slow_tune_o | output | 4 | Slow oscillator coarse tune, two's complement |
| fast_tune_o | output | 5 | Fast oscillator tune, two's complement |
| divisor_o | output | 16 | Tick divisor, unsigned 5.11 fixed point |
| done_o | output | 1 | One-cycle pulse when a run ends |

## Verification
The reset values and the start-time loads of R2 are due one clock after the accepted start edge, and the bench samples them on the following falling edge. The tune codes, the divisor and the end of a run have data-dependent latency: settle waits, strobe alignment and a 32-cycle division. The bench therefore waits for done_o at falling edges and reads every result in the cycle done_o is high, because the final divisor and tune are written on that same edge. One cycle later it confirms done_o has dropped and that the run lasted at least the required number of settle waits.

// File: rtl/rc_cal_pkg.sv
package rc_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SL_BASE,
    ST_SL_TUNE,
    ST_SL_AVG,
    ST_SL_DIV_GO,
    ST_SL_DIV_RUN,
    ST_FA_MEAS
  } cal_state_e;

  localparam logic [15:0] DIV_RESET       = 16'h5000;
  localparam int unsigned DIV_NUMERATOR   = 384000000;

endpackage

// File: rtl/rc_settle_timer.sv
module rc_settle_timer #(
  parameter int unsigned SLOW_CYC = 100,
  parameter int unsigned FAST_CYC = 10,
  localparam int unsigned MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC,
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic fast_i,
  output logic expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= fast_i ? CNT_W'(FAST_CYC) : CNT_W'(SLOW_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/rc_div_restoring.sv
module rc_div_restoring #(
  parameter int unsigned DVD_W = 32,
  parameter int unsigned DVS_W = 16,
  parameter int unsigned QUO_W = 16,
  localparam int unsigned CNT_W = $clog2(DVD_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             done_o,
  output logic [QUO_W-1:0] quot_o
);

  logic [DVS_W:0]   rem_q;
  logic [DVD_W-1:0] dvd_q;
  logic [DVS_W-1:0] dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  logic [DVS_W:0] rem_sh, rem_sub;
  logic           ge;

  always_comb begin
    rem_sh  = {rem_q[DVS_W-1:0], dvd_q[DVD_W-1]};
    ge      = (rem_sh >= {1'b0, dvs_q});
    rem_sub = rem_sh - {1'b0, dvs_q};
  end

  // dvd_q shifts the dividend out at the top and the quotient in at the bottom
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      dvd_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        rem_q  <= '0;
        dvd_q  <= dividend_i;
        dvs_q  <= divisor_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? rem_sub : rem_sh;
        dvd_q <= {dvd_q[DVD_W-2:0], ge};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(DVD_W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = dvd_q[QUO_W-1:0];

endmodule

// File: rtl/rc_cal_seq.sv
module rc_cal_seq
  import rc_cal_pkg::*;
#(
  parameter int unsigned CLK_MHZ        = 12,
  parameter int unsigned SLOW_SETTLE_US = 4250,
  parameter int unsigned FAST_SETTLE_US = 128,
  parameter int unsigned PERIOD_W       = 16,
  parameter int unsigned SLOW_TUNE_W    = 4,
  parameter int unsigned FAST_TUNE_W    = 5,
  parameter int unsigned DIV_W          = 16,
  parameter int unsigned SAMPLES_LOG2   = 3,
  parameter int unsigned SLOW_TARGET    = 19200,
  parameter int unsigned SLOW_STEP      = 800,
  parameter int unsigned FAST_TARGET    = 256
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   mode_i,
  input  logic [PERIOD_W-1:0]    period_i,
  input  logic                   period_vld_i,
  output logic [SLOW_TUNE_W-1:0] slow_tune_o,
  output logic [FAST_TUNE_W-1:0] fast_tune_o,
  output logic [DIV_W-1:0]       divisor_o,
  output logic                   done_o
);

  localparam int unsigned SLOW_CYC = SLOW_SETTLE_US * CLK_MHZ;
  localparam int unsigned FAST_CYC = FAST_SETTLE_US * CLK_MHZ;
  localparam int unsigned SUM_W    = PERIOD_W + SAMPLES_LOG2 + 1;
  localparam int unsigned DVD_W    = 32;
  localparam int unsigned DIFF_W   = PERIOD_W + 2;
  localparam int          SL_MAX   = 2 ** (SLOW_TUNE_W - 1) - 1;
  localparam int          SL_MIN   = -(2 ** (SLOW_TUNE_W - 1));
  localparam logic signed [DIFF_W-1:0] SL_TGT_S  = DIFF_W'(SLOW_TARGET + SLOW_STEP / 2);
  localparam logic signed [DIFF_W-1:0] SL_STEP_S = DIFF_W'(SLOW_STEP);
  localparam logic [FAST_TUNE_W-1:0] FA_MIN = {1'b1, {(FAST_TUNE_W-1){1'b0}}};
  localparam logic [FAST_TUNE_W-1:0] FA_MAX = {1'b0, {(FAST_TUNE_W-1){1'b1}}};
  localparam logic [SUM_W-1:0] RND_HALF = SUM_W'(2 ** (SAMPLES_LOG2 - 1));

  cal_state_e state_q, state_d;

  logic [SLOW_TUNE_W-1:0]  slow_tune_q;
  logic [FAST_TUNE_W-1:0]  fast_tune_q;
  logic [DIV_W-1:0]        divisor_q;
  logic                    done_q;
  logic [SUM_W-1:0]        sum_q;
  logic [SAMPLES_LOG2-1:0] smp_cnt_q;

  logic tmr_load, tmr_fast, tmr_expired, smp_ok, div_go, div_done, finish;
  logic fa_stop;
  logic [DIV_W-1:0] quot;

  logic signed [DIFF_W-1:0] diff_s, step_s;
  logic [SLOW_TUNE_W-1:0]   coarse_c;
  logic [SUM_W-1:0]         sum_rnd;
  logic [PERIOD_W-1:0]      avg_c;

  rc_settle_timer #(
    .SLOW_CYC (SLOW_CYC),
    .FAST_CYC (FAST_CYC)
  ) i_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .fast_i    (tmr_fast),
    .expired_o (tmr_expired)
  );

  rc_div_restoring #(
    .DVD_W (DVD_W),
    .DVS_W (PERIOD_W),
    .QUO_W (DIV_W)
  ) i_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_go),
    .dividend_i (DVD_W'(DIV_NUMERATOR)),
    .divisor_i  (avg_c),
    .done_o     (div_done),
    .quot_o     (quot)
  );

  // coarse step: rounded, truncating signed divide, then clamp to tune range
  always_comb begin
    diff_s = SL_TGT_S - $signed({2'b00, period_i});
    step_s = diff_s / SL_STEP_S;
    if (step_s > SL_MAX)      coarse_c = SLOW_TUNE_W'(SL_MAX);
    else if (step_s < SL_MIN) coarse_c = SLOW_TUNE_W'(SL_MIN);
    else                      coarse_c = SLOW_TUNE_W'(step_s);
  end

  always_comb begin
    sum_rnd = sum_q + RND_HALF;
    avg_c   = PERIOD_W'(sum_rnd >> SAMPLES_LOG2);
  end

  assign smp_ok  = tmr_expired && period_vld_i;
  assign fa_stop = (period_i >= PERIOD_W'(FAST_TARGET)) || (fast_tune_q == FA_MAX);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_fast = 1'b0;
    div_go   = 1'b0;
    finish   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          tmr_load = 1'b1;
          tmr_fast = mode_i;
          state_d  = mode_i ? ST_FA_MEAS : ST_SL_BASE;
        end
      end
      ST_SL_BASE: begin
        if (smp_ok) begin
          tmr_load = 1'b1;
          state_d  = ST_SL_TUNE;
        end
      end
      ST_SL_TUNE: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          state_d  = ST_SL_AVG;
        end
      end
      ST_SL_AVG: begin
        if (smp_ok) begin
          if (&smp_cnt_q) state_d = ST_SL_DIV_GO;
          else            tmr_load = 1'b1;
        end
      end
      ST_SL_DIV_GO: begin
        div_go  = 1'b1;
        state_d = ST_SL_DIV_RUN;
      end
      ST_SL_DIV_RUN: begin
        if (div_done) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_FA_MEAS: begin
        tmr_fast = 1'b1;
        if (smp_ok) begin
          if (fa_stop) begin
            finish  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            tmr_load = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      slow_tune_q <= '0;
      fast_tune_q <= '0;
      divisor_q   <= DIV_RESET;
      done_q      <= 1'b0;
      sum_q       <= '0;
      smp_cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && !mode_i) begin
            slow_tune_q <= '0;
            divisor_q   <= DIV_RESET;
          end else if (start_i) begin
            fast_tune_q <= FA_MIN;
          end
        end
        ST_SL_BASE:    if (smp_ok) slow_tune_q <= coarse_c;
        ST_SL_TUNE: begin
          if (tmr_expired) begin
            sum_q     <= '0;
            smp_cnt_q <= '0;
          end
        end
        ST_SL_AVG: begin
          if (smp_ok) begin
            sum_q     <= sum_q + SUM_W'(period_i);
            smp_cnt_q <= smp_cnt_q + 1'b1;
          end
        end
        ST_SL_DIV_RUN: if (div_done) divisor_q <= quot;
        ST_FA_MEAS:    if (smp_ok && !fa_stop) fast_tune_q <= fast_tune_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign slow_tune_o = slow_tune_q;
  assign fast_tune_o = fast_tune_q;
  assign divisor_o   = divisor_q;
  assign done_o      = done_q;

endmodule

// File: rtl/rc_cal_seq_chk.sv
module rc_cal_seq_chk
  import rc_cal_pkg::*;
#(
  parameter int unsigned SLOW_TUNE_W = 4,
  parameter int unsigned FAST_TUNE_W = 5,
  parameter int unsigned DIV_W       = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic                   mode_i,
  input logic [SLOW_TUNE_W-1:0] slow_tune_o,
  input logic [FAST_TUNE_W-1:0] fast_tune_o,
  input logic [DIV_W-1:0]       divisor_o,
  input logic                   done_o,
  input cal_state_e             state_q
);

  localparam logic [FAST_TUNE_W-1:0] FA_MIN = {1'b1, {(FAST_TUNE_W-1){1'b0}}};

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_SLOW_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && !mode_i) |=>
      (divisor_o == DIV_W'(16'h5000) && slow_tune_o == '0)); // R2

  AST_FAST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && mode_i) |=> (fast_tune_o == FA_MIN)); // R6

  AST_FAST_TUNE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fast_tune_o) |->
      (fast_tune_o == $past(fast_tune_o) + 1'b1 || fast_tune_o == FA_MIN)); // R6

  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_FA_MEAS && start_i) |=> $stable(fast_tune_o)); // R8

  AST_FAST_KEEPS_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FA_MEAS) |=> ($stable(divisor_o) && $stable(slow_tune_o))); // R10

  AST_DIV_WRITE_POINTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(divisor_o) |->
      ($past(state_q) == ST_IDLE || $past(state_q) == ST_SL_DIV_RUN)); // R5

endmodule

bind rc_cal_seq rc_cal_seq_chk #(
  .SLOW_TUNE_W (SLOW_TUNE_W),
  .FAST_TUNE_W (FAST_TUNE_W),
  .DIV_W       (DIV_W)
) i_chk (.*);

// File: tb/test_rc_cal_seq.sv
module test_rc_cal_seq;

  localparam int SLOW_US = 20;
  localparam int FAST_US = 3;
  localparam int NVEC = 10;
  // mode, baseline period, fast step per tune code
  localparam int V_MODE [NVEC] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1};
  localparam int V_BASE [NVEC] = '{19200, 15000, 30000, 9000, 20500, 19999, 256, 300, 100, 600};
  localparam int V_STEP [NVEC] = '{0, 0, 0, 0, 0, 0, 16, 10, 5, 8};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [15:0] period;
  logic        period_vld = 1'b0;
  logic [3:0]  slow_tune;
  logic [4:0]  fast_tune;
  logic [15:0] divisor;
  logic        done;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int done_cnt = 0;
  int model_mode = 0;
  int model_base = 0;
  int model_step = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rc_cal_seq #(
    .CLK_MHZ        (1),
    .SLOW_SETTLE_US (SLOW_US),
    .FAST_SETTLE_US (FAST_US)
  ) i_rc_cal_seq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .mode_i       (mode),
    .period_i     (period),
    .period_vld_i (period_vld),
    .slow_tune_o  (slow_tune),
    .fast_tune_o  (fast_tune),
    .divisor_o    (divisor),
    .done_o       (done)
  );

  function automatic int sat16(input int v);
    if (v < 0) return 0;
    if (v > 65535) return 65535;
    return v;
  endfunction

  // oscillator model: period grows with tune code
  always_comb begin
    if (model_mode == 1) period = 16'(sat16(model_base + int'($signed(fast_tune)) * model_step));
    else                 period = 16'(sat16(model_base + int'($signed(slow_tune)) * 800));
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) done_cnt <= done_cnt + 1;
  end

  always @(negedge clk) period_vld <= (cyc % 3 == 0);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
      finish_sim();
    end
  end

  function automatic int exp_slow_tune(input int base);
    int d;
    d = (19600 - base) / 800;
    if (d > 7) d = 7;
    if (d < -8) d = -8;
    return d;
  endfunction

  function automatic int exp_fast_tune(input int base, input int step);
    for (int t = -16; t <= 15; t++) begin
      if (sat16(base + t * step) >= 256 || t == 15) return t;
    end
    return 15;
  endfunction

  // start a run; optionally pulse a second start in the middle; return cycles to done
  task automatic run_cal(input int m, input int base, input int step,
                         input bit poke, output int dur);
    int k;
    int d0;
    model_mode = m;
    model_base = base;
    model_step = step;
    d0 = done_cnt;
    @(negedge clk);
    mode  = m[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (m == 0) begin
      chk("R2 divisor reload", int'(divisor), 16'h5000);
      chk("R2 slow tune reload", int'(slow_tune), 0);
    end else begin
      chk("R6 fast tune starts at -16", int'($signed(fast_tune)), -16);
    end
    k = 1;
    if (poke) begin
      repeat (5) @(negedge clk);
      mode  = ~m[0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      mode  = m[0];
      k = k + 6;
    end
    while (!done && k < 20000) begin
      @(negedge clk);
      k++;
    end
    dur = k;
    chk("R9 done seen", int'(done), 1);
    @(negedge clk);
    chk("R9 done one cycle", int'(done), 0);
    chk("R9 one pulse per run", done_cnt - d0, 1);
  endtask

  initial begin
    int dur;
    int prev_fast, prev_slow, prev_div;
    int et, avg;
    repeat (3) @(negedge clk);
    chk("R1 slow tune reset", int'(slow_tune), 0);
    chk("R1 fast tune reset", int'(fast_tune), 0);
    chk("R1 divisor reset", int'(divisor), 16'h5000);
    chk("R1 done reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      prev_fast = int'(fast_tune);
      prev_slow = int'(slow_tune);
      prev_div  = int'(divisor);
      run_cal(V_MODE[i], V_BASE[i], V_STEP[i], 1'b0, dur);
      if (V_MODE[i] == 0) begin
        et  = exp_slow_tune(V_BASE[i]);
        avg = sat16(V_BASE[i] + et * 800);
        chk("R3 coarse slow tune", int'($signed(slow_tune)), et);
        chk("R5 divisor from average", int'(divisor), (384000000 / avg) & 16'hffff);
        chk("R4 ten slow settle waits", int'(dur >= 10 * SLOW_US), 1);
        chk("R10 slow run keeps fast tune", int'(fast_tune), prev_fast);
      end else begin
        et = exp_fast_tune(V_BASE[i], V_STEP[i]);
        chk("R6 R7 fast sweep result", int'($signed(fast_tune)), et);
        chk("R4 fast settle waits", int'(dur >= (et + 17) * FAST_US), 1);
        chk("R10 fast run keeps slow tune", int'(slow_tune), prev_slow);
        chk("R10 fast run keeps divisor", int'(divisor), prev_div);
      end
    end

    // R7: range exhausted ends at +15
    run_cal(1, 10, 1, 1'b0, dur);
    chk("R7 sweep ends at +15", int'($signed(fast_tune)), 15);

    // R8: fast start during a slow run is ignored
    prev_fast = int'(fast_tune);
    run_cal(0, 17000, 0, 1'b1, dur);
    et  = exp_slow_tune(17000);
    avg = sat16(17000 + et * 800);
    chk("R8 fast tune untouched", int'(fast_tune), prev_fast);
    chk("R8 slow result intact", int'(divisor), (384000000 / avg) & 16'hffff);

    // R8: slow start during a fast run is ignored
    prev_div  = int'(divisor);
    prev_slow = int'(slow_tune);
    run_cal(1, 300, 10, 1'b1, dur);
    chk("R8 divisor untouched", int'(divisor), prev_div);
    chk("R8 slow tune untouched", int'(slow_tune), prev_slow);
    chk("R8 fast result intact", int'($signed(fast_tune)), exp_fast_tune(300, 10));

    finish_sim();
  end

endmodule